// File: doc/BRIEF.md
# Dual-Mode IDE Channel Address Decoder

This block decodes host I/O addresses for a two-channel disk controller that appears as a PCI configuration function. It keeps a programming-interface byte and four relocatable I/O base registers: one command window and one control window for each channel. These registers are reached through a small byte-wide configuration port. For every I/O address it reports which channel was hit, whether the command block or the control block was selected, and the register offset within that block. It also routes each channel's device interrupt.

Each channel has a mode bit that software can change at any time, and the two channels switch independently. In compatibility mode a channel answers at its fixed ports and drives its own dedicated interrupt line. In relocatable mode the channel decodes from its base registers, but only while I/O space is enabled, and it drives one shared level-sensitive PCI interrupt. The decode outputs are combinational. Configuration writes take effect on the next rising clock edge.

Top module: `ide_chan_decode`

## Requirements
- R1: The programming-interface byte is at config offset 0x0 and reads 0x0A after reset. Bit 0 (channel 0 mode) and bit 2 (channel 1 mode) are read/write, with 1 meaning relocatable. Bits 1 and 3 always read 1, and bits 7:4 always read 0, whatever is written.
- R2: The base registers are byte-addressed, low byte first: channel 0 command at 0x8/0x9, channel 0 control at 0xA/0xB, channel 1 command at 0xC/0xD, and channel 1 control at 0xE/0xF. Each reads 0x0001 after reset. Unmapped offsets read 0x00 and ignore writes.
- R3: Command base bits [2:0] always read 001 and control base bits [1:0] always read 01. Writes to those bits have no effect on readback or on decode.
- R4: In compatibility mode, channel 0 decodes 0x1F0–0x1F7 as the command block with offset addr[2:0]. It decodes only 0x3F6 as the control block, with offset 2.
- R5: In compatibility mode, channel 1 decodes 0x170–0x177 as the command block and only 0x376 as the control block, using the same offsets as R4.
- R6: In relocatable mode, a channel's command block is the 8 bytes at its command base, with offset addr[2:0]. Its control block is the 4 bytes at its control base, with offset addr[1:0]. Its fixed compatibility ports are no longer decoded.
- R7: A relocatable channel decodes nothing while io_space_en_i is low. A compatibility channel decodes regardless of io_space_en_i.
- R8: The channels' modes are independent, so one channel can be relocatable while the other keeps its fixed ports.
- R9: irq14_o follows dev_irq_i[0] and irq15_o follows dev_irq_i[1] only while the matching channel is in compatibility mode. pci_int_o is the OR of the device interrupts of the relocatable channels.
- R10: At most one of cmd_sel_o and ctl_sel_o is active. hit_o is one-hot for the selected channel, or zero on a miss, in which case reg_off_o is 0. On overlap, channel 0 wins over channel 1, and within a channel the command block wins over the control block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 4 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_addr_i |
| io_space_en_i | input | 1 | I/O space enable from the command register |
| io_addr_i | input | 16 | Host I/O address |
| dev_irq_i | input | 2 | Device interrupt request per channel |
| hit_o | output | 2 | One-hot channel hit |
| cmd_sel_o | output | 1 | Command block selected |
| ctl_sel_o | output | 1 | Control block selected |
| reg_off_o | output | 3 | Register offset within the selected block |
| irq14_o | output | 1 | Channel 0 compatibility interrupt |
| irq15_o | output | 1 | Channel 1 compatibility interrupt |
| pci_int_o | output | 1 | Shared relocatable-mode interrupt |

## Verification
The hardest states to reach are overlapping windows: two relocatable channels programmed to the same base, or a control window that overlaps the command window of the same channel. The priority rules only show up in those states. Directed steps program such overlaps explicitly and then probe addresses inside them. The random phase draws I/O addresses mostly near the current base registers and fixed ports, so mixed-mode and overlap states keep recurring as configuration writes change the map.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int unsigned IO_AW  = 16;
  localparam int unsigned NCH    = 2;
  localparam int unsigned CFG_AW = 4;
  localparam int unsigned OFF_W  = 3;

  typedef logic [IO_AW-1:0] io_addr_t;

  typedef struct packed {
    logic             cmd;
    logic             ctl;
    logic [OFF_W-1:0] off;
  } win_t;

  function automatic io_addr_t leg_cmd_base(int ch);
    return (ch == 0) ? io_addr_t'(16'h01F0) : io_addr_t'(16'h0170);
  endfunction

  // 4-byte aligned; only base+2 is decoded in compatibility mode
  function automatic io_addr_t leg_ctl_base(int ch);
    return (ch == 0) ? io_addr_t'(16'h03F4) : io_addr_t'(16'h0374);
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [CFG_AW-1:0]         cfg_addr_i,
  input  logic [7:0]                cfg_wdata_i,
  output logic [7:0]                cfg_rdata_o,
  output logic [NCH-1:0]            native_o,
  output logic [NCH-1:0][IO_AW-1:0] cmd_base_o,
  output logic [NCH-1:0][IO_AW-1:0] ctl_base_o
);
  localparam logic [CFG_AW-1:0] PI_ADDR = '0;

  logic [7:0] progif;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      localparam logic [CFG_AW-1:0] CMD_LO = CFG_AW'(8 + 4*c);
      localparam logic [CFG_AW-1:0] CMD_HI = CFG_AW'(9 + 4*c);
      localparam logic [CFG_AW-1:0] CTL_LO = CFG_AW'(10 + 4*c);
      localparam logic [CFG_AW-1:0] CTL_HI = CFG_AW'(11 + 4*c);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          native_o[c] <= 1'b0;
        end else if (cfg_we_i && cfg_addr_i == PI_ADDR) begin
          native_o[c] <= cfg_wdata_i[2*c];
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cmd_base_o[c] <= IO_AW'(1);
          ctl_base_o[c] <= IO_AW'(1);
        end else if (cfg_we_i) begin
          // low bits hardwired: I/O indicator plus block alignment
          if (cfg_addr_i == CMD_LO) cmd_base_o[c][7:0]       <= {cfg_wdata_i[7:3], 3'b001};
          if (cfg_addr_i == CMD_HI) cmd_base_o[c][IO_AW-1:8] <= cfg_wdata_i;
          if (cfg_addr_i == CTL_LO) ctl_base_o[c][7:0]       <= {cfg_wdata_i[7:2], 2'b01};
          if (cfg_addr_i == CTL_HI) ctl_base_o[c][IO_AW-1:8] <= cfg_wdata_i;
        end
      end
    end
  endgenerate

  always_comb begin
    progif = '0;
    for (int i = 0; i < NCH; i++) begin
      progif[2*i]   = native_o[i];
      progif[2*i+1] = 1'b1;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == PI_ADDR) cfg_rdata_o = progif;
    for (int i = 0; i < NCH; i++) begin
      if (cfg_addr_i == CFG_AW'(8 + 4*i))  cfg_rdata_o = cmd_base_o[i][7:0];
      if (cfg_addr_i == CFG_AW'(9 + 4*i))  cfg_rdata_o = cmd_base_o[i][IO_AW-1:8];
      if (cfg_addr_i == CFG_AW'(10 + 4*i)) cfg_rdata_o = ctl_base_o[i][7:0];
      if (cfg_addr_i == CFG_AW'(11 + 4*i)) cfg_rdata_o = ctl_base_o[i][IO_AW-1:8];
    end
  end

  AST_MODE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == PI_ADDR) |=> (native_o == {$past(cfg_wdata_i[2]), $past(cfg_wdata_i[0])})); // R1
  AST_CMD_LOW_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == 4'h8 || cfg_addr_i == 4'hC) |-> cfg_rdata_o[2:0] == 3'b001); // R3
  AST_CTL_LOW_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i == 4'hA || cfg_addr_i == 4'hE) |-> cfg_rdata_o[1:0] == 2'b01); // R3
endmodule

// File: rtl/ide_chan_window.sv
module ide_chan_window
  import ide_dec_pkg::*;
#(
  parameter int unsigned CH = 0
) (
  input  logic     native_i,
  input  logic     io_en_i,
  input  io_addr_t addr_i,
  input  io_addr_t cmd_base_i,
  input  io_addr_t ctl_base_i,
  output win_t     win_o
);
  localparam io_addr_t LEG_CMD = leg_cmd_base(CH);
  localparam io_addr_t LEG_CTL = io_addr_t'(leg_ctl_base(CH) + 2);

  logic cmd_hit, ctl_hit;

  always_comb begin
    if (native_i) begin
      cmd_hit = io_en_i && (addr_i[IO_AW-1:3] == cmd_base_i[IO_AW-1:3]);
      ctl_hit = io_en_i && (addr_i[IO_AW-1:2] == ctl_base_i[IO_AW-1:2]);
    end else begin
      cmd_hit = (addr_i[IO_AW-1:3] == LEG_CMD[IO_AW-1:3]);
      ctl_hit = (addr_i == LEG_CTL);
    end
  end

  always_comb begin
    win_o.cmd = cmd_hit;
    win_o.ctl = ctl_hit && !cmd_hit;
    if (cmd_hit)      win_o.off = addr_i[2:0];
    else if (ctl_hit) win_o.off = {1'b0, addr_i[1:0]};
    else              win_o.off = '0;
  end
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route
  import ide_dec_pkg::*;
(
  input  logic [NCH-1:0] native_i,
  input  logic [NCH-1:0] dev_irq_i,
  output logic           irq14_o,
  output logic           irq15_o,
  output logic           pci_int_o
);
  assign irq14_o   = dev_irq_i[0] && !native_i[0];
  assign irq15_o   = dev_irq_i[1] && !native_i[1];
  assign pci_int_o = |(dev_irq_i & native_i);
endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode
  import ide_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              io_space_en_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic [NCH-1:0]    dev_irq_i,
  output logic [NCH-1:0]    hit_o,
  output logic              cmd_sel_o,
  output logic              ctl_sel_o,
  output logic [OFF_W-1:0]  reg_off_o,
  output logic              irq14_o,
  output logic              irq15_o,
  output logic              pci_int_o
);
  logic [NCH-1:0]            native;
  logic [NCH-1:0][IO_AW-1:0] cmd_base, ctl_base;
  win_t                      win [NCH];

  ide_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .native_o    (native),
    .cmd_base_o  (cmd_base),
    .ctl_base_o  (ctl_base)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_win
      ide_chan_window #(.CH(c)) u_win (
        .native_i   (native[c]),
        .io_en_i    (io_space_en_i),
        .addr_i     (io_addr_i),
        .cmd_base_i (cmd_base[c]),
        .ctl_base_i (ctl_base[c]),
        .win_o      (win[c])
      );
    end
  endgenerate

  // lowest channel index wins on overlap
  always_comb begin
    hit_o     = '0;
    cmd_sel_o = 1'b0;
    ctl_sel_o = 1'b0;
    reg_off_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (win[i].cmd || win[i].ctl) begin
        hit_o     = NCH'(1) << i;
        cmd_sel_o = win[i].cmd;
        ctl_sel_o = win[i].ctl;
        reg_off_o = win[i].off;
      end
    end
  end

  ide_irq_route u_irq (
    .native_i  (native),
    .dev_irq_i (dev_irq_i),
    .irq14_o   (irq14_o),
    .irq15_o   (irq15_o),
    .pci_int_o (pci_int_o)
  );

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_sel_o && ctl_sel_o) && $onehot0(hit_o) && ((hit_o != '0) == (cmd_sel_o || ctl_sel_o))); // R10
  AST_NATIVE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_space_en_i && native[0]) |-> !hit_o[0]); // R7
  AST_LEG_PRI_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!native[0] && io_addr_i == 16'h01F3) |-> (hit_o == 2'b01 && cmd_sel_o && reg_off_o == 3'd3)); // R4
  AST_PCI_INT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_int_o |-> |(dev_irq_i & native)); // R9
  AST_IRQ14_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq14_o |-> (!native[0] && dev_irq_i[0])); // R9
endmodule

// File: tb/tb_ide_chan_decode.sv
module tb_ide_chan_decode;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        io_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  dev_irq = '0;
  logic [1:0]  hit;
  logic        cmd_sel, ctl_sel;
  logic [2:0]  reg_off;
  logic        irq14, irq15, pci_int;

  int tests = 0, fails = 0;
  bit done = 0;

  logic        m_native [2];
  logic [15:0] m_cmd [2];
  logic [15:0] m_ctl [2];

  always #(CLK_P/2) clk = ~clk;

  ide_chan_decode dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .io_space_en_i(io_en),
    .io_addr_i(io_addr), .dev_irq_i(dev_irq), .hit_o(hit), .cmd_sel_o(cmd_sel),
    .ctl_sel_o(ctl_sel), .reg_off_o(reg_off), .irq14_o(irq14), .irq15_o(irq15),
    .pci_int_o(pci_int)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model_wr(logic [3:0] a, logic [7:0] d);
    case (a)
      4'h0: begin m_native[0] = d[0]; m_native[1] = d[2]; end
      4'h8: m_cmd[0][7:0]  = {d[7:3], 3'b001};
      4'h9: m_cmd[0][15:8] = d;
      4'hA: m_ctl[0][7:0]  = {d[7:2], 2'b01};
      4'hB: m_ctl[0][15:8] = d;
      4'hC: m_cmd[1][7:0]  = {d[7:3], 3'b001};
      4'hD: m_cmd[1][15:8] = d;
      4'hE: m_ctl[1][7:0]  = {d[7:2], 2'b01};
      4'hF: m_ctl[1][15:8] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    case (a)
      4'h0: return {4'h0, 1'b1, m_native[1], 1'b1, m_native[0]};
      4'h8: return m_cmd[0][7:0];
      4'h9: return m_cmd[0][15:8];
      4'hA: return m_ctl[0][7:0];
      4'hB: return m_ctl[0][15:8];
      4'hC: return m_cmd[1][7:0];
      4'hD: return m_cmd[1][15:8];
      4'hE: return m_ctl[1][7:0];
      4'hF: return m_ctl[1][15:8];
      default: return 8'h00;
    endcase
  endfunction

  // {hit[1:0], cmd, ctl, off[2:0]}
  function automatic logic [6:0] exp_dec(logic [15:0] a, bit en);
    for (int c = 0; c < 2; c++) begin
      bit ch, th;
      if (m_native[c]) begin
        ch = en && (a[15:3] == m_cmd[c][15:3]);
        th = en && (a[15:2] == m_ctl[c][15:2]);
      end else begin
        ch = (a[15:3] == ((c == 0) ? 13'h003E : 13'h002E));
        th = (a == ((c == 0) ? 16'h03F6 : 16'h0376));
      end
      if (ch) return {(c == 0) ? 2'b01 : 2'b10, 2'b10, a[2:0]};
      if (th) return {(c == 0) ? 2'b01 : 2'b10, 2'b01, 1'b0, a[1:0]};
    end
    return 7'd0;
  endfunction

  task automatic cfg_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    model_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, string req);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(cfg_rdata === exp_rd(a), req, cfg_rdata, exp_rd(a));
  endtask

  task automatic io_chk(logic [15:0] a, bit en, string req);
    logic [6:0] e;
    @(negedge clk);
    io_addr = a; io_en = en;
    #2;
    e = exp_dec(a, en);
    check({hit, cmd_sel, ctl_sel, reg_off} === e, req, {a, 9'd0, hit, cmd_sel, ctl_sel, reg_off}, {a, 9'd0, e});
  endtask

  task automatic irq_chk(logic [1:0] irq, string req);
    logic [2:0] e;
    @(negedge clk);
    dev_irq = irq;
    #2;
    e = {irq[0] & ~m_native[0], irq[1] & ~m_native[1], |(irq & {m_native[1], m_native[0]})};
    check({irq14, irq15, pci_int} === e, req, {29'd0, irq14, irq15, pci_int}, {29'd0, e});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1DE5_0A0F));
    for (int c = 0; c < 2; c++) begin
      m_native[c] = 1'b0; m_cmd[c] = 16'h0001; m_ctl[c] = 16'h0001;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd_chk(4'h0, "R1 reset progif");
    for (int a = 8; a < 16; a++) rd_chk(4'(a), "R2 reset base");
    rd_chk(4'h3, "R2 unmapped");

    io_chk(16'h01F0, 1, "R4 pri cmd lo");
    io_chk(16'h01F7, 0, "R4 pri cmd hi no io_en");
    io_chk(16'h03F6, 1, "R4 pri ctl");
    io_chk(16'h03F7, 1, "R4 pri ctl neighbour miss");
    io_chk(16'h03F4, 1, "R4 pri ctl base miss");
    io_chk(16'h0170, 1, "R5 sec cmd");
    io_chk(16'h0177, 1, "R5 sec cmd hi");
    io_chk(16'h0376, 0, "R5 sec ctl");
    io_chk(16'h01F8, 1, "R10 miss");
    irq_chk(2'b11, "R9 legacy irq");

    cfg_wr(4'h0, 8'hFF); rd_chk(4'h0, "R1 ro bits");
    cfg_wr(4'h0, 8'h00); rd_chk(4'h0, "R1 clear");
    cfg_wr(4'h3, 8'hAA); rd_chk(4'h3, "R2 unmapped write");
    cfg_wr(4'h8, 8'hFF); rd_chk(4'h8, "R3 cmd low bits");
    cfg_wr(4'hA, 8'hFF); rd_chk(4'hA, "R3 ctl low bits");

    cfg_wr(4'h8, 8'h00); cfg_wr(4'h9, 8'hC0);
    cfg_wr(4'hA, 8'h0A); cfg_wr(4'hB, 8'hC0);
    cfg_wr(4'h0, 8'h01); rd_chk(4'h0, "R8 pri native only");
    for (int o = 0; o < 8; o++) io_chk(16'hC000 + 16'(o), 1, "R6 native cmd");
    io_chk(16'hC00A, 1, "R6 R3 native ctl");
    io_chk(16'hC00B, 1, "R6 native ctl");
    io_chk(16'hC00C, 1, "R6 native ctl miss");
    io_chk(16'h01F0, 1, "R6 legacy ports dropped");
    io_chk(16'h0170, 1, "R8 sec stays legacy");
    io_chk(16'hC000, 0, "R7 native gated");
    io_chk(16'h0170, 0, "R7 legacy ungated");
    irq_chk(2'b11, "R9 mixed irq");
    irq_chk(2'b01, "R9 pri native irq");

    cfg_wr(4'hC, 8'h00); cfg_wr(4'hD, 8'hC0);
    cfg_wr(4'h0, 8'h05);
    io_chk(16'hC003, 1, "R10 channel priority");
    irq_chk(2'b10, "R9 sec native irq");
    cfg_wr(4'hA, 8'h04);
    io_chk(16'hC005, 1, "R10 cmd over ctl");
    io_chk(16'h0376, 1, "R6 sec legacy ctl dropped");

    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 3) begin
        cfg_wr(4'($urandom_range(0, 15)), 8'($urandom));
      end else if (r == 3) begin
        rd_chk(4'($urandom_range(0, 15)), "R1 R2 R3 random read");
      end else if (r == 4) begin
        irq_chk(2'($urandom), "R9 random irq");
      end else begin
        logic [15:0] a;
        case ($urandom_range(0, 5))
          0: a = m_cmd[$urandom_range(0, 1)] + 16'($urandom_range(0, 9)) - 16'd1;
          1: a = m_ctl[$urandom_range(0, 1)] + 16'($urandom_range(0, 5)) - 16'd1;
          2: a = 16'h01F0 + 16'($urandom_range(0, 8));
          3: a = 16'h0170 + 16'($urandom_range(0, 8));
          4: a = ($urandom_range(0, 1) != 0) ? 16'h03F6 : 16'h0376;
          default: a = 16'($urandom);
        endcase
        io_chk(a, 1'($urandom), "R4 R5 R6 R7 R10 random decode");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule